// File: doc/BRIEF.md
# Non-Blocking Direct-Mapped Write-Through Cache

This block is a single-way-per-set cache placed between a word-oriented requester and a slower next-level memory. The requester presents one read or write per cycle and gets an answer in the same cycle. The answer is one of three kinds. A hit returns the word. A retry carries a stall count that estimates how long the requester should wait before it tries again. A fault reports that the line's refill hit an invalid address.

A miss never blocks the cache. Each set keeps its own pending-refill record, with a countdown, a word counter and an error flag. That record lets misses to several sets overlap their waiting time. One shared next-level port serves the refills one word read at a time. Only one read is in flight on that port at any time. A write-through can use the port only when it is free.

Reads and writes that hit are answered with no wait. A write that misses starts a line allocation in the same way a read miss does, and the requester then retries the write until it hits. A write that hits updates the cached word and forwards the same write to the next level in the same cycle.

Top module: `dm_wt_cache`

## Requirements
- R1: After reset every line is invalid and no refill is pending. With no request, rsp_kind is 0 (idle) and mem_req_valid is low.
- R2: Addresses split into three fields. The low log2(LINE_WORDS*4) bits are the byte offset, and bits [log2(LINE_WORDS*4)-1:2] select the word. The next log2(NUM_SETS) bits are the set index, and the tag is the remaining high bits. A request hits only when the indexed line is valid and its tag matches. A hit answers rsp_kind 1 with the selected word. A line replaced by another tag at the same index no longer hits.
- R3: A miss on a set with no pending refill answers rsp_kind 2 (retry) with rsp_stall equal to NL_LATENCY, and opens a refill of the line-aligned address.
- R4: A miss on a set whose refill is pending (and not in error) answers retry with the refill's current countdown as rsp_stall.
- R5: A pending refill's countdown drops by one each cycle while it is above 1. At 1 it reads the line's words in ascending order, starting from its saved word counter.
- R6: A next-level response with code 1 (stall) reloads the countdown with the returned count (at least 1). The refill then resumes at the same word, and the line still fills with correct data.
- R7: A next-level response with code 2 (invalid address) puts the refill in error. A retry to the same line answers rsp_kind 3 (fault). A request to a different line at that index restarts the refill with the error cleared and answers retry with stall NL_LATENCY.
- R8: A line becomes valid, with its new tag and data, only after its last word arrives with code 0 (data). The pending record is then cleared.
- R9: A write performs the read lookup. On a miss or fault it returns that answer unchanged, forwards nothing and allocates the line. On a hit it updates the word and drives the same address and data as a write on the next-level port in that cycle.
- R10: A refill that ends in error never makes its line valid, so requests to that line never hit.
- R11: At most one next-level read is outstanding. Refills in different sets take turns on the port.
- R12: A write hit while a next-level read is outstanding, or while the port is not ready, answers retry with stall 1 and forwards nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Write data |
| rsp_kind | output | 2 | 0 idle, 1 hit, 2 retry, 3 fault |
| rsp_rdata | output | DATA_W | Word returned on a hit |
| rsp_stall | output | CNT_W | Stall estimate on retry |
| mem_req_valid | output | 1 | Next-level request valid |
| mem_req_write | output | 1 | Next-level request is a write-through |
| mem_req_addr | output | ADDR_W | Next-level word address |
| mem_req_wdata | output | DATA_W | Next-level write data |
| mem_req_ready | input | 1 | Next level accepts the request |
| mem_rsp_valid | input | 1 | Read response present |
| mem_rsp_code | input | 2 | 0 data, 1 stall, 2 invalid address |
| mem_rsp_rdata | input | DATA_W | Read response data |
| mem_rsp_stall | input | CNT_W | Stall count for code 1 |

## Verification
The hardest case to reach is a write hit that arrives exactly while a refill read is in flight. To reach it, the stimulus opens a miss and then sends requests to that line on back-to-back cycles. The stall answers step through the countdown to 1, and the write lands in the cycle after the read issues. The next-level model injects a one-time stall on the third word of a chosen line and an invalid-address fault on a high address range. These exercise the resume and error-capture paths. A second model-side counter flags any overlap of reads.

// File: rtl/cache_pkg.sv
package cache_pkg;
  typedef enum logic [1:0] {
    RSP_IDLE  = 2'd0,
    RSP_HIT   = 2'd1,
    RSP_RETRY = 2'd2,
    RSP_FAULT = 2'd3
  } rsp_kind_e;

  typedef enum logic [1:0] {
    NL_DATA  = 2'd0,
    NL_STALL = 2'd1,
    NL_BAD   = 2'd2
  } nl_code_e;
endpackage

// File: rtl/cache_addr_split.sv
module cache_addr_split #(
  parameter int UPPER_W = 30,
  parameter int WORD_W  = 2,
  parameter int IDX_W   = 2
) (
  input  logic [UPPER_W-1:0]              word_addr,
  output logic [UPPER_W-WORD_W-IDX_W-1:0] tag_o,
  output logic [IDX_W-1:0]                idx_o,
  output logic [WORD_W-1:0]               word_o
);
  localparam int TAG_W = UPPER_W - WORD_W - IDX_W;

  assign word_o = word_addr[WORD_W-1:0];
  assign idx_o  = word_addr[WORD_W+IDX_W-1:WORD_W];
  assign tag_o  = word_addr[UPPER_W-1:UPPER_W-TAG_W];
endmodule

// File: rtl/cache_refill_slot.sv
module cache_refill_slot #(
  parameter int CNT_W   = 8,
  parameter int WORD_W  = 2,
  parameter int LATENCY = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              rsp_data_i,
  input  logic              rsp_stall_i,
  input  logic              rsp_err_i,
  input  logic [CNT_W-1:0]  stall_val_i,
  output logic              pend_o,
  output logic              err_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [WORD_W-1:0] wcnt_o,
  output logic              ready_o,
  output logic              done_o
);
  localparam logic [WORD_W-1:0] LAST_WORD = {WORD_W{1'b1}};
  localparam logic [CNT_W-1:0]  ONE       = CNT_W'(1);

  logic              pend_q, pend_d, err_q, err_d, upd;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [WORD_W-1:0] wcnt_q, wcnt_d;

  assign upd = start_i | pend_q;

  always_comb begin
    pend_d = pend_q;
    err_d  = err_q;
    cnt_d  = cnt_q;
    wcnt_d = wcnt_q;
    if (start_i) begin
      pend_d = 1'b1;
      err_d  = 1'b0;
      cnt_d  = CNT_W'(LATENCY);
      wcnt_d = '0;
    end else if (pend_q) begin
      if (rsp_data_i) begin
        if (wcnt_q == LAST_WORD) pend_d = 1'b0;
        else                     wcnt_d = wcnt_q + 1'b1;
      end else if (rsp_stall_i) begin
        cnt_d = (stall_val_i == '0) ? ONE : stall_val_i;
      end else if (rsp_err_i) begin
        err_d = 1'b1;
      end else if (!err_q && cnt_q > ONE) begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      err_q  <= 1'b0;
      cnt_q  <= '0;
      wcnt_q <= '0;
    end else if (upd) begin
      pend_q <= pend_d;
      err_q  <= err_d;
      cnt_q  <= cnt_d;
      wcnt_q <= wcnt_d;
    end
  end

  assign pend_o  = pend_q;
  assign err_o   = err_q;
  assign cnt_o   = cnt_q;
  assign wcnt_o  = wcnt_q;
  assign ready_o = pend_q && !err_q && (cnt_q == ONE);
  assign done_o  = pend_q && !err_q && rsp_data_i && (wcnt_q == LAST_WORD);

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !err_q && cnt_q > ONE && !start_i && !rsp_stall_i)
      |=> (cnt_q == $past(cnt_q) - 1'b1)); // R5
  AST_FILL_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !pend_q); // R8
  AST_FAULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !start_i) |=> (err_q && pend_q)); // R7
  AST_STALL_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_stall_i && pend_q && !start_i) |=> (cnt_q != '0)); // R6
endmodule

// File: rtl/dm_wt_cache.sv
module dm_wt_cache
  import cache_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int NUM_SETS    = 4,
  parameter int LINE_WORDS  = 4,
  parameter int CNT_W       = 8,
  parameter int NL_LATENCY  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [1:0]        rsp_kind,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [CNT_W-1:0]  rsp_stall,
  output logic              mem_req_valid,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [DATA_W-1:0] mem_req_wdata,
  input  logic              mem_req_ready,
  input  logic              mem_rsp_valid,
  input  logic [1:0]        mem_rsp_code,
  input  logic [DATA_W-1:0] mem_rsp_rdata,
  input  logic [CNT_W-1:0]  mem_rsp_stall
);
  localparam int BYTE_W  = $clog2(DATA_W / 8);
  localparam int WORD_W  = $clog2(LINE_WORDS);
  localparam int IDX_W   = $clog2(NUM_SETS);
  localparam int UPPER_W = ADDR_W - BYTE_W;
  localparam int TAG_W   = UPPER_W - WORD_W - IDX_W;

  // reset: asserted asynchronously, released through two flops
  logic [1:0] rst_sync_q;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i = rst_sync_q[1];

  logic [TAG_W-1:0]  r_tag;
  logic [IDX_W-1:0]  r_idx;
  logic [WORD_W-1:0] r_word;

  cache_addr_split #(.UPPER_W(UPPER_W), .WORD_W(WORD_W), .IDX_W(IDX_W)) u_split (
    .word_addr (req_addr[ADDR_W-1:BYTE_W]),
    .tag_o     (r_tag),
    .idx_o     (r_idx),
    .word_o    (r_word)
  );

  logic [NUM_SETS-1:0] valid_q;
  logic [TAG_W-1:0]    tag_q  [NUM_SETS];
  logic [DATA_W-1:0]   data_q [NUM_SETS][LINE_WORDS];
  logic                busy_q;
  logic [IDX_W-1:0]    owner_q;

  logic [NUM_SETS-1:0] pend_v, err_v, ready_v, done_v, start_v;
  logic [NUM_SETS-1:0] rd_v, st_v, bad_v;
  logic [CNT_W-1:0]    cnt_v  [NUM_SETS];
  logic [WORD_W-1:0]   wcnt_v [NUM_SETS];

  for (genvar g = 0; g < NUM_SETS; g++) begin : g_slot
    logic mine;
    assign mine       = mem_rsp_valid && busy_q && (owner_q == IDX_W'(g));
    assign rd_v[g]    = mine && (mem_rsp_code == NL_DATA);
    assign st_v[g]    = mine && (mem_rsp_code == NL_STALL);
    assign bad_v[g]   = mine && (mem_rsp_code == NL_BAD);

    cache_refill_slot #(.CNT_W(CNT_W), .WORD_W(WORD_W), .LATENCY(NL_LATENCY)) u_slot (
      .clk         (clk),
      .rst_n       (rst_i),
      .start_i     (start_v[g]),
      .rsp_data_i  (rd_v[g]),
      .rsp_stall_i (st_v[g]),
      .rsp_err_i   (bad_v[g]),
      .stall_val_i (mem_rsp_stall),
      .pend_o      (pend_v[g]),
      .err_o       (err_v[g]),
      .cnt_o       (cnt_v[g]),
      .wcnt_o      (wcnt_v[g]),
      .ready_o     (ready_v[g]),
      .done_o      (done_v[g])
    );
  end

  // lookup and answer
  rsp_kind_e  kind_d;
  logic [CNT_W-1:0] stall_d;
  logic hit, same_line, wt_ok, wt_go, start_any;

  assign same_line = (tag_q[r_idx] == r_tag);
  assign hit       = valid_q[r_idx] && same_line;
  assign wt_ok     = !busy_q && mem_req_ready;

  always_comb begin
    kind_d    = RSP_IDLE;
    stall_d   = '0;
    start_any = 1'b0;
    wt_go     = 1'b0;
    if (req_valid) begin
      if (hit) begin
        if (!req_write || wt_ok) begin
          kind_d = RSP_HIT;
          wt_go  = req_write;
        end else begin
          kind_d  = RSP_RETRY;
          stall_d = CNT_W'(1);
        end
      end else if (!pend_v[r_idx] || (err_v[r_idx] && !same_line)) begin
        kind_d    = RSP_RETRY;
        stall_d   = CNT_W'(NL_LATENCY);
        start_any = 1'b1;
      end else if (err_v[r_idx]) begin
        kind_d = RSP_FAULT;
      end else begin
        kind_d  = RSP_RETRY;
        stall_d = cnt_v[r_idx];
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_SETS; i++) start_v[i] = start_any && (r_idx == IDX_W'(i));
  end

  assign rsp_kind  = kind_d;
  assign rsp_stall = stall_d;
  assign rsp_rdata = data_q[r_idx][r_word];

  // next-level port: lowest ready set wins, write-through has priority
  logic [IDX_W-1:0] pick;
  logic             any_ready, rf_go, rf_fire;
  always_comb begin
    pick      = '0;
    any_ready = 1'b0;
    for (int i = NUM_SETS - 1; i >= 0; i--) begin
      if (ready_v[i]) begin
        pick      = IDX_W'(i);
        any_ready = 1'b1;
      end
    end
  end

  assign rf_go   = any_ready && !busy_q && !wt_go;
  assign rf_fire = rf_go && mem_req_ready;

  assign mem_req_valid = wt_go || rf_go;
  assign mem_req_write = wt_go;
  assign mem_req_addr  = wt_go ? req_addr
                               : {tag_q[pick], pick, wcnt_v[pick], {BYTE_W{1'b0}}};
  assign mem_req_wdata = req_wdata;

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      busy_q  <= 1'b0;
      owner_q <= '0;
    end else begin
      if (rf_fire) begin
        busy_q  <= 1'b1;
        owner_q <= pick;
      end else if (mem_rsp_valid) begin
        busy_q  <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      valid_q <= '0;
    end else begin
      for (int i = 0; i < NUM_SETS; i++) begin
        if (start_v[i])     valid_q[i] <= 1'b0;
        else if (done_v[i]) valid_q[i] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (start_any) tag_q[r_idx] <= r_tag;
  end

  always_ff @(posedge clk) begin
    if (|rd_v) data_q[owner_q][wcnt_v[owner_q]] <= mem_rsp_rdata;
    if (wt_go)  data_q[r_idx][r_word]            <= req_wdata;
  end

  AST_SINGLE_READ: assert property (@(posedge clk) disable iff (!rst_i)
    (mem_req_valid && mem_req_ready && !mem_req_write)
      |=> !(mem_req_valid && !mem_req_write)); // R11
  AST_WT_FORWARD: assert property (@(posedge clk) disable iff (!rst_i)
    (req_valid && req_write && rsp_kind == RSP_HIT)
      |-> (mem_req_valid && mem_req_write && mem_req_ready && mem_req_addr == req_addr
           && mem_req_wdata == req_wdata)); // R9
  AST_FAULT_INVALID: assert property (@(posedge clk) disable iff (!rst_i)
    (rsp_kind == RSP_FAULT) |-> !valid_q[r_idx]); // R10
  AST_BUSY_WRITE_RETRY: assert property (@(posedge clk) disable iff (!rst_i)
    (req_valid && req_write && busy_q) |-> (rsp_kind != RSP_HIT)); // R12
endmodule

// File: tb/dm_wt_cache_test.sv
module dm_wt_cache_test;
  localparam logic [1:0] K_IDLE = 2'd0, K_HIT = 2'd1, K_RETRY = 2'd2, K_FAULT = 2'd3;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write;
  logic [31:0] req_addr, req_wdata;
  logic [1:0]  rsp_kind;
  logic [31:0] rsp_rdata;
  logic [7:0]  rsp_stall;
  logic        mem_req_valid, mem_req_write;
  logic [31:0] mem_req_addr, mem_req_wdata;
  logic        mem_req_ready;
  logic        mem_rsp_valid;
  logic [1:0]  mem_rsp_code;
  logic [31:0] mem_rsp_rdata;
  logic [7:0]  mem_rsp_stall;

  always #5 clk = ~clk;

  dm_wt_cache uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_kind(rsp_kind), .rsp_rdata(rsp_rdata), .rsp_stall(rsp_stall),
    .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata), .mem_req_ready(mem_req_ready),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_code(mem_rsp_code),
    .mem_rsp_rdata(mem_rsp_rdata), .mem_rsp_stall(mem_rsp_stall)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // ---------------- next-level memory model ----------------
  logic [31:0] mem_w [logic [31:0]];
  logic [31:0] wr_a [$];
  logic [31:0] wr_d [$];
  bit          stall_armed = 0;
  logic [31:0] stall_addr = '0;
  int          overlap = 0;

  function automatic logic [31:0] patt(input logic [31:0] a);
    return mem_w.exists(a) ? mem_w[a] : {~a[15:0], a[15:0]};
  endfunction

  initial begin
    bit rd_busy = 0;
    int delay = 0;
    logic [31:0] rd_addr = '0;
    mem_req_ready = 1'b1;
    mem_rsp_valid = 1'b0;
    mem_rsp_code  = 2'd0;
    mem_rsp_rdata = '0;
    mem_rsp_stall = '0;
    forever begin
      @(posedge clk);
      mem_rsp_valid <= 1'b0;
      if (rd_busy) begin
        if (delay == 0) begin
          rd_busy = 0;
          mem_rsp_valid <= 1'b1;
          if (rd_addr[31]) begin
            mem_rsp_code <= 2'd2;
          end else if (stall_armed && rd_addr == stall_addr) begin
            stall_armed = 0;
            mem_rsp_code  <= 2'd1;
            mem_rsp_stall <= 8'd4;
          end else begin
            mem_rsp_code  <= 2'd0;
            mem_rsp_rdata <= patt(rd_addr);
          end
        end else delay--;
      end
      if (mem_req_valid && mem_req_ready) begin
        if (mem_req_write) begin
          wr_a.push_back(mem_req_addr);
          wr_d.push_back(mem_req_wdata);
          mem_w[mem_req_addr] = mem_req_wdata;
        end else begin
          if (rd_busy) overlap++;
          rd_busy = 1;
          rd_addr = mem_req_addr;
          delay   = 1;
        end
      end
    end
  end

  // ---------------- scoreboard ----------------
  typedef struct {
    logic [1:0]  kind;
    logic [31:0] data;
    bit          chk_d;
    logic [7:0]  stall;
    bit          chk_s;
    string       rq;
  } exp_t;
  exp_t sb [$];
  bit nochk = 0;

  task automatic send(input bit wr, input logic [31:0] a, input logic [31:0] d,
                      input logic [1:0] k, input logic [31:0] ed, input bit cd,
                      input logic [7:0] es, input bit cs, input string rq);
    exp_t e;
    @(posedge clk); #1;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; nochk = 0;
    e.kind = k; e.data = ed; e.chk_d = cd; e.stall = es; e.chk_s = cs; e.rq = rq;
    sb.push_back(e);
  endtask

  task automatic idle();
    @(posedge clk); #1;
    req_valid = 1'b0; req_write = 1'b0; nochk = 0;
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (req_valid && !nochk) begin
        if (sb.size() == 0) begin
          chk(1'b0, "scoreboard-empty", 32'(rsp_kind), 32'hFFFF_FFFF);
        end else begin
          exp_t e;
          e = sb.pop_front();
          chk(rsp_kind == e.kind, {e.rq, " kind"}, 32'(rsp_kind), 32'(e.kind));
          if (e.chk_d) chk(rsp_rdata == e.data, {e.rq, " data"}, rsp_rdata, e.data);
          if (e.chk_s) chk(rsp_stall == e.stall, {e.rq, " stall"}, 32'(rsp_stall), 32'(e.stall));
        end
      end
    end
  end

  task automatic poll(input bit wr, input logic [31:0] a, input logic [31:0] d,
                      input logic [1:0] want, input string rq, output logic [31:0] got);
    bit ok = 0;
    got = '0;
    for (int i = 0; i < 80; i++) begin
      @(posedge clk); #1;
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; nochk = 1;
      @(negedge clk);
      if (rsp_kind == want) begin
        ok = 1; got = rsp_rdata;
        break;
      end else if (rsp_kind != K_RETRY) begin
        break;
      end
    end
    chk(ok, {rq, " poll"}, 32'(rsp_kind), 32'(want));
    idle();
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [31:0] got;
    int n;
    req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(rsp_kind == K_IDLE, "R1 idle kind", 32'(rsp_kind), 32'(K_IDLE));
    chk(mem_req_valid == 1'b0, "R1 no memory request", 32'(mem_req_valid), 0);

    // first miss, countdown visible to retries
    send(0, 32'h100, 0, K_RETRY, 0, 0, 8'd3, 1, "R1 R3 cold miss");
    send(0, 32'h104, 0, K_RETRY, 0, 0, 8'd3, 1, "R4 pending countdown");
    send(0, 32'h108, 0, K_RETRY, 0, 0, 8'd2, 1, "R5 countdown step");
    idle();
    poll(0, 32'h10C, 0, K_HIT, "R8 fill", got);
    chk(got == patt(32'h10C), "R8 fill data", got, patt(32'h10C));
    send(0, 32'h100, 0, K_HIT, patt(32'h100), 1, 0, 0, "R2 word 0");
    send(0, 32'h108, 0, K_HIT, patt(32'h108), 1, 0, 0, "R2 word 2");
    idle();

    // write hit with write-through
    n = wr_a.size();
    send(1, 32'h104, 32'hDEAD_BEEF, K_HIT, 0, 0, 0, 0, "R9 write hit");
    idle();
    repeat (2) @(posedge clk);
    chk(wr_a.size() == n + 1, "R9 write-through count", wr_a.size(), n + 1);
    if (wr_a.size() == n + 1) begin
      chk(wr_a[n] == 32'h104, "R9 write-through addr", wr_a[n], 32'h104);
      chk(wr_d[n] == 32'hDEAD_BEEF, "R9 write-through data", wr_d[n], 32'hDEAD_BEEF);
    end
    send(0, 32'h104, 0, K_HIT, 32'hDEAD_BEEF, 1, 0, 0, "R9 updated word");
    idle();

    // write miss allocates, evicting 0x100's line
    n = wr_a.size();
    send(1, 32'h204, 32'h1234_5678, K_RETRY, 0, 0, 8'd3, 1, "R9 write miss");
    idle();
    repeat (2) @(posedge clk);
    chk(wr_a.size() == n, "R9 no forward on miss", wr_a.size(), n);
    poll(1, 32'h204, 32'h1234_5678, K_HIT, "R9 allocate", got);
    send(0, 32'h204, 0, K_HIT, 32'h1234_5678, 1, 0, 0, "R9 allocated word");
    send(0, 32'h100, 0, K_RETRY, 0, 0, 8'd3, 1, "R2 evicted tag");
    idle();
    poll(0, 32'h104, 0, K_HIT, "R2 refetch", got);
    chk(got == 32'hDEAD_BEEF, "R9 written-through data refetched", got, 32'hDEAD_BEEF);

    // invalid address path
    send(0, 32'h8000_0010, 0, K_RETRY, 0, 0, 8'd3, 1, "R7 bad line miss");
    idle();
    poll(0, 32'h8000_0010, 0, K_FAULT, "R7 fault reported", got);
    send(0, 32'h8000_0010, 0, K_FAULT, 0, 0, 0, 0, "R7 fault repeats");
    send(0, 32'h8000_0018, 0, K_FAULT, 0, 0, 0, 0, "R10 never valid");
    send(0, 32'h0000_0410, 0, K_RETRY, 0, 0, 8'd3, 1, "R7 restart other line");
    idle();
    poll(0, 32'h414, 0, K_HIT, "R7 restarted fill", got);
    chk(got == patt(32'h414), "R7 restarted data", got, patt(32'h414));

    // next-level stall mid-line
    stall_addr = 32'h628; stall_armed = 1;
    send(0, 32'h620, 0, K_RETRY, 0, 0, 8'd3, 1, "R6 miss");
    idle();
    poll(0, 32'h62C, 0, K_HIT, "R6 resumed fill", got);
    chk(stall_armed == 0, "R6 stall injected", 32'(stall_armed), 0);
    chk(got == patt(32'h62C), "R6 last word", got, patt(32'h62C));
    send(0, 32'h620, 0, K_HIT, patt(32'h620), 1, 0, 0, "R6 word 0");
    send(0, 32'h624, 0, K_HIT, patt(32'h624), 1, 0, 0, "R6 word 1");
    send(0, 32'h628, 0, K_HIT, patt(32'h628), 1, 0, 0, "R6 stalled word");
    idle();

    // write hit while a refill read is in flight
    send(0, 32'h930, 0, K_RETRY, 0, 0, 8'd3, 1, "R3 miss set 3");
    send(0, 32'h930, 0, K_RETRY, 0, 0, 8'd3, 1, "R4 pending");
    send(0, 32'h934, 0, K_RETRY, 0, 0, 8'd2, 1, "R5 step to 2");
    send(0, 32'h938, 0, K_RETRY, 0, 0, 8'd1, 1, "R5 step to 1");
    n = wr_a.size();
    send(1, 32'h624, 32'hCAFE_0001, K_RETRY, 0, 0, 8'd1, 1, "R12 port busy");
    idle();
    repeat (2) @(posedge clk);
    chk(wr_a.size() == n, "R12 nothing forwarded", wr_a.size(), n);
    poll(0, 32'h93C, 0, K_HIT, "R12 refill done", got);
    poll(1, 32'h624, 32'hCAFE_0001, K_HIT, "R12 write later", got);
    send(0, 32'h624, 0, K_HIT, 32'hCAFE_0001, 1, 0, 0, "R12 word written");
    idle();

    // two sets refilling together
    send(0, 32'h730, 0, K_RETRY, 0, 0, 8'd3, 1, "R11 miss set 3");
    send(0, 32'h840, 0, K_RETRY, 0, 0, 8'd3, 1, "R11 miss set 0");
    idle();
    poll(0, 32'h734, 0, K_HIT, "R11 first line", got);
    chk(got == patt(32'h734), "R11 first data", got, patt(32'h734));
    poll(0, 32'h84C, 0, K_HIT, "R11 second line", got);
    chk(got == patt(32'h84C), "R11 second data", got, patt(32'h84C));
    chk(overlap == 0, "R11 single outstanding read", overlap, 0);

    repeat (3) @(posedge clk);
    chk(sb.size() == 0, "scoreboard drained", sb.size(), 0);
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule